// File: doc/BRIEF.md
# Accumulator ALU with Packed-Decimal Arithmetic

This block is the arithmetic and logic unit of an 8-bit accumulator processor. Each cycle it takes the accumulator value, one operand byte, the current carry and overflow flags, a decimal-mode flag and a 3-bit operation code. From these it produces a result byte and new negative, overflow, zero and carry flags. Addition and subtraction run either in plain two's-complement binary or in packed BCD, two decimal digits per byte. The decimal path keeps the flag behaviour of the early NMOS parts: negative and overflow are always cleared, zero follows the corrected byte, and carry comes from the digit-correction chain.

The result and flags appear combinationally. A capture register holds the result and flags from the last cycle in which the capture strobe was high, so a pipeline can write them back later. Operand fetch, addressing and instruction decode belong to the surrounding core.

Top module: `acc_alu8`

## Requirements
- R1: With op code 0 (add) and decimal mode clear, res_o = (acc_i + opnd_i + c_i) mod 256. c_o is set when the 9-bit sum exceeds 255. v_o is set when acc_i and opnd_i have the same bit 7 and res_o has the other. n_o is res_o bit 7 and z_o is set when res_o is zero.
- R2: With op code 1 (subtract) and decimal mode clear, the block adds the bitwise inverse of opnd_i plus c_i, and every output follows the rules of R1 with the inverted operand.
- R3: With op code 0 and decimal mode set, each 4-bit digit, from the low one up, sums its two digits plus the incoming carry. Starting from c_i for the low digit, that sum gets 6 added when it exceeds 9. The next digit's carry is set when the corrected sum exceeds 15. c_o is the carry out of the top digit, and res_o is the low four bits of each corrected sum.
- R4: With op code 1 and decimal mode set, each digit takes the difference of its two digits minus a borrow, starting with the inverse of c_i. It subtracts 6 when bit 4 of the 5-bit difference is set, and bit 4 of that corrected value is the borrow into the next digit. c_o is set only when the top digit's uncorrected difference is between 0 and 14 inclusive.
- R5: In decimal mode, add and subtract drive n_o and v_o to 0, and z_o is set exactly when res_o is zero.
- R6: Op code 5 (compare) outputs res_o = acc_i and sets c_o when acc_i >= opnd_i as unsigned numbers. z_o is set when they are equal, n_o is bit 7 of (acc_i - opnd_i) mod 256, and v_o equals v_i. Decimal mode has no effect on compare.
- R7: Op codes 2, 3 and 4 output acc_i AND, OR and XOR opnd_i respectively. n_o is bit 7 of the result, z_o is set when the result is zero, c_o equals c_i and v_o equals v_i. Decimal mode has no effect on these codes.
- R8: Op codes 6 and 7 output res_o = acc_i with n_o and z_o taken from acc_i, c_o = c_i and v_o = v_i.
- R9: On a rising clock edge with cap_i high, res_q takes res_o and flags_q takes {n_o, v_o, z_o, c_o} (bit 3 = N, bit 0 = C). With cap_i low, both keep their value.
- R10: A rising edge with rst high clears res_q and flags_q to 0, and this takes priority over cap_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the capture register |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code (0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 compare, 6/7 pass) |
| acc_i | input | 8 | Accumulator or compared register value |
| opnd_i | input | 8 | Operand byte |
| c_i | input | 1 | Current carry flag |
| v_i | input | 1 | Current overflow flag |
| dec_i | input | 1 | Decimal-mode flag |
| cap_i | input | 1 | Capture strobe for the result register |
| res_o | output | 8 | Combinational result |
| n_o | output | 1 | Combinational negative flag |
| v_o | output | 1 | Combinational overflow flag |
| z_o | output | 1 | Combinational zero flag |
| c_o | output | 1 | Combinational carry flag |
| res_q | output | 8 | Captured result |
| flags_q | output | 4 | Captured flags {N, V, Z, C} |

## Verification
Add and subtract are swept over every accumulator, operand and carry-in value in both binary and decimal mode, against a reference model written from the requirements. The binary sweep separates correct overflow detection from a sign-only check. The decimal sweep includes non-decimal digits A to F, which is where the NMOS borrow taken from bit 4 and the carry rule for a top digit difference of 15 show up. The logic, compare and pass codes are swept over all byte pairs with carry, overflow and decimal inputs varied, so any flag that leaks through from an input is caught. Hand-computed vectors pin down known decimal cases such as 99+01 and 00-00 with borrow, and directed tests check capture, hold and the priority of reset over capture.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = 4;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_CMP  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    function automatic logic is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

    function automatic logic is_bitwise(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction
endpackage

// File: rtl/alu8_binadd.sv
`timescale 1ns/1ps
// Two's-complement adder; with sub set the operand is inverted first.
module alu8_binadd #(
    parameter int W = alu8_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;

    assign b_eff = sub ? ~b : b;
    assign full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    assign sum   = full[W-1:0];
    assign cout  = full[W];
    // Overflow: inputs agree in sign, result disagrees
    assign ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/alu8_bcd.sv
`timescale 1ns/1ps
// Packed-decimal add/subtract, one correction stage per digit.
module alu8_bcd #(
    parameter int W  = alu8_pkg::DATA_W,
    parameter int NW = alu8_pkg::NIB_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int ND = W / NW;
    localparam int AW = NW + 2;   // add digit: up to 2*(2^NW-1)+1+6
    localparam int SW = NW + 1;   // sub digit: bit NW is the sign / borrow
    localparam logic [AW-1:0] DEC_MAX = AW'(9);
    localparam logic [AW-1:0] DIG_MAX = AW'((1 << NW) - 1);
    localparam logic [AW-1:0] ADJ_A   = AW'(6);
    localparam logic [SW-1:0] ADJ_S   = SW'(6);
    localparam logic [NW-1:0] TOP_ALL = {NW{1'b1}};

    logic [ND:0]   chain;        // carry (add) or borrow (sub) between digits
    logic [SW-1:0] top_raw;

    assign chain[0] = sub ? ~cin : cin;

    for (genvar d = 0; d < ND; d++) begin : g_dig
        logic [NW-1:0] da, db;
        logic [AW-1:0] a_raw, a_fix;
        logic [SW-1:0] s_raw, s_fix;

        assign da    = a[d*NW +: NW];
        assign db    = b[d*NW +: NW];
        assign a_raw = AW'(da) + AW'(db) + AW'(chain[d]);
        assign a_fix = (a_raw > DEC_MAX) ? a_raw + ADJ_A : a_raw;
        assign s_raw = SW'(da) - SW'(db) - SW'(chain[d]);
        assign s_fix = s_raw[NW] ? s_raw - ADJ_S : s_raw;

        assign chain[d+1]        = sub ? s_fix[NW] : (a_fix > DIG_MAX);
        assign res[d*NW +: NW]   = sub ? s_fix[NW-1:0] : a_fix[NW-1:0];

        if (d == ND - 1) begin : g_top
            assign top_raw = s_raw;
        end
    end

    // Subtract carry: top difference non-negative and not all-ones
    assign cout = sub ? (!top_raw[NW] && (top_raw[NW-1:0] != TOP_ALL))
                      : chain[ND];
endmodule

// File: rtl/alu8_logic.sv
`timescale 1ns/1ps
module alu8_logic import alu8_pkg::*; #(
    parameter int W = DATA_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/acc_alu8.sv
`timescale 1ns/1ps
module acc_alu8 import alu8_pkg::*; #(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   op_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opnd_i,
    input  logic         c_i,
    input  logic         v_i,
    input  logic         dec_i,
    input  logic         cap_i,
    output logic [W-1:0] res_o,
    output logic         n_o,
    output logic         v_o,
    output logic         z_o,
    output logic         c_o,
    output logic [W-1:0] res_q,
    output logic [3:0]   flags_q
);
    alu_op_e op;
    assign op = alu_op_e'(op_i);

    // Binary adder is shared by add, subtract and compare
    logic         add_sub, add_cin, add_cout, add_ovf;
    logic [W-1:0] add_sum;
    assign add_sub = (op == OP_SUB) || (op == OP_CMP);
    assign add_cin = (op == OP_CMP) ? 1'b1 : c_i;

    alu8_binadd #(.W(W)) u_bin (
        .a(acc_i), .b(opnd_i), .cin(add_cin), .sub(add_sub),
        .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
    );

    logic [W-1:0] bcd_res;
    logic         bcd_cout;
    alu8_bcd #(.W(W), .NW(NIB_W)) u_bcd (
        .a(acc_i), .b(opnd_i), .cin(c_i), .sub(op == OP_SUB),
        .res(bcd_res), .cout(bcd_cout)
    );

    logic [W-1:0] log_res;
    alu8_logic #(.W(W)) u_log (.op(op), .a(acc_i), .b(opnd_i), .y(log_res));

    logic [W-1:0] res_n;
    flags_t       flg_n;

    always_comb begin
        res_n = acc_i;
        flg_n = '{n: acc_i[W-1], v: v_i, z: (acc_i == '0), c: c_i};
        if (is_arith(op)) begin
            if (dec_i) begin
                res_n = bcd_res;
                flg_n = '{n: 1'b0, v: 1'b0, z: (bcd_res == '0), c: bcd_cout};
            end else begin
                res_n = add_sum;
                flg_n = '{n: add_sum[W-1], v: add_ovf, z: (add_sum == '0), c: add_cout};
            end
        end else if (is_bitwise(op)) begin
            res_n = log_res;
            flg_n = '{n: log_res[W-1], v: v_i, z: (log_res == '0), c: c_i};
        end else if (op == OP_CMP) begin
            flg_n = '{n: add_sum[W-1], v: v_i, z: (acc_i == opnd_i), c: add_cout};
        end
    end

    assign res_o = res_n;
    assign n_o   = flg_n.n;
    assign v_o   = flg_n.v;
    assign z_o   = flg_n.z;
    assign c_o   = flg_n.c;

    flags_t flg_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            flg_q <= '0;
        end else if (cap_i) begin
            res_q <= res_n;
            flg_q <= flg_n;
        end
    end
    assign flags_q = flg_q;

    // R5
    dec_nv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_i && (op_i <= 3'd1)) |-> (!n_o && !v_o && (z_o == (res_o == '0))));
    // R6
    cmp_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd5) |-> ((res_o == acc_i) && (v_o == v_i) && (c_o == (acc_i >= opnd_i))));
    // R7
    bitwise_pass_chk: assert property (@(posedge clk) disable iff (rst)
        ((op_i >= 3'd2) && (op_i <= 3'd4)) |-> ((c_o == c_i) && (v_o == v_i)));
    // R1
    bin_nz_chk: assert property (@(posedge clk) disable iff (rst)
        (!dec_i && (op_i <= 3'd1)) |-> ((n_o == res_o[W-1]) && (z_o == (res_o == '0))));
    // R9
    cap_load_chk: assert property (@(posedge clk) disable iff (rst)
        cap_i |=> ((res_q == $past(res_o)) && (flags_q == $past({n_o, v_o, z_o, c_o}))));
    // R9
    cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_i |=> ($stable(res_q) && $stable(flags_q)));
    // R10
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> ((res_q == '0) && (flags_q == 4'd0)));
endmodule

// File: tb/acc_alu8_test.sv
`timescale 1ns/1ps
module acc_alu8_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] op_i;
    logic [7:0] acc_i, opnd_i;
    logic       c_i, v_i, dec_i, cap_i;
    logic [7:0] res_o, res_q;
    logic       n_o, v_o, z_o, c_o;
    logic [3:0] flags_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    acc_alu8 uut (
        .clk(clk), .rst(rst), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
        .c_i(c_i), .v_i(v_i), .dec_i(dec_i), .cap_i(cap_i),
        .res_o(res_o), .n_o(n_o), .v_o(v_o), .z_o(z_o), .c_o(c_o),
        .res_q(res_q), .flags_q(flags_q)
    );

    // Entry: {op[2:0], dec, c, v, acc[7:0], opnd[7:0], res[7:0], {N,V,Z,C}}
    localparam int NV = 17;
    localparam logic [33:0] VEC [NV] = '{
        {3'd0, 3'b000, 8'h50, 8'h50, 8'hA0, 4'b1100},  // R1 overflow
        {3'd0, 3'b010, 8'hFF, 8'h00, 8'h00, 4'b0011},  // R1 carry wrap
        {3'd0, 3'b110, 8'h58, 8'h46, 8'h05, 4'b0001},  // R3
        {3'd0, 3'b100, 8'h99, 8'h01, 8'h00, 4'b0011},  // R3
        {3'd0, 3'b100, 8'h79, 8'h10, 8'h89, 4'b0000},  // R5 N forced low
        {3'd1, 3'b110, 8'h46, 8'h12, 8'h34, 4'b0001},  // R4
        {3'd1, 3'b110, 8'h12, 8'h21, 8'h91, 4'b0000},  // R4 borrow
        {3'd1, 3'b010, 8'h50, 8'hB0, 8'hA0, 4'b1100},  // R2 overflow
        {3'd1, 3'b100, 8'h00, 8'h00, 8'h99, 4'b0000},  // R4 borrow-in
        {3'd1, 3'b000, 8'h00, 8'h00, 8'hFF, 4'b1000},  // R2 borrow-in
        {3'd5, 3'b001, 8'h42, 8'h42, 8'h42, 4'b0111},  // R6 equal
        {3'd5, 3'b110, 8'h10, 8'h20, 8'h10, 4'b1000},  // R6 less
        {3'd4, 3'b010, 8'hAA, 8'hFF, 8'h55, 4'b0001},  // R7 xor
        {3'd2, 3'b001, 8'hF0, 8'h0F, 8'h00, 4'b0110},  // R7 and
        {3'd3, 3'b111, 8'h80, 8'h01, 8'h81, 4'b1101},  // R7 or
        {3'd6, 3'b001, 8'h00, 8'hFF, 8'h00, 4'b0110},  // R8
        {3'd7, 3'b010, 8'hC3, 8'h00, 8'hC3, 4'b1001}   // R8
    };

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag(input int op, input int dm);
        if (op == 0) return (dm != 0) ? "R3" : "R1";
        if (op == 1) return (dm != 0) ? "R4" : "R2";
        if (op == 5) return "R6";
        if (op >= 6) return "R8";
        return "R7";
    endfunction

    // Reference model built from the requirements: {res, N, V, Z, C}
    function automatic logic [11:0] model(input int op, input int dm, input int ci,
                                          input int vi, input int a, input int b);
        int r, s, lo, hi, bb;
        logic n, v, z, c;
        r = a; c = ci[0]; v = vi[0]; s = 0;
        if (op <= 1 && dm == 0) begin
            bb = (op == 1) ? (b ^ 255) : b;
            s  = a + bb + ci;
            r  = s & 255;
            c  = (s > 255);
            v  = (((a ^ bb) & 128) == 0) && (((a ^ r) & 128) != 0);
        end else if (op == 0) begin
            lo = (a & 15) + (b & 15) + ci;
            if (lo > 9) lo += 6;
            hi = (a >> 4) + (b >> 4) + ((lo > 15) ? 1 : 0);
            if (hi > 9) hi += 6;
            r = ((hi & 15) << 4) | (lo & 15);
            c = (hi > 15);
        end else if (op == 1) begin
            lo = (a & 15) - (b & 15) - ((ci != 0) ? 0 : 1);
            if ((lo & 16) != 0) lo -= 6;
            hi = (a >> 4) - (b >> 4) - (((lo & 16) != 0) ? 1 : 0);
            if ((hi & 16) != 0) hi -= 6;
            r = ((hi & 15) << 4) | (lo & 15);
            c = ((hi & 255) < 15);
        end else if (op == 2) r = a & b;
        else if (op == 3) r = a | b;
        else if (op == 4) r = a ^ b;
        n = ((r & 128) != 0);
        z = (r == 0);
        if (op <= 1 && dm != 0) begin
            n = 1'b0; v = 1'b0;
        end
        if (op == 5) begin
            s = (a - b) & 255;
            n = ((s & 128) != 0);
            z = (a == b);
            c = (a >= b);
        end
        return {r[7:0], n, v, z, c};
    endfunction

    task automatic drive(input int op, input int dm, input int ci, input int vi,
                         input int a, input int b);
        op_i = op[2:0]; dec_i = dm[0]; c_i = ci[0]; v_i = vi[0];
        acc_i = a[7:0]; opnd_i = b[7:0];
    endtask

    task automatic run_one(input int op, input int dm, input int ci, input int vi,
                           input int a, input int b);
        drive(op, dm, ci, vi, a, b);
        #1;
        chk(tag(op, dm), {res_o, n_o, v_o, z_o, c_o}, model(op, dm, ci, vi, a, b));
        if (op <= 1 && dm != 0)
            chk("R5", {10'd0, n_o, v_o}, 12'd0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cap_i = 1'b1;
        drive(0, 0, 0, 0, 8'h12, 8'h34);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset wins over an active capture strobe
        chk("R10", {res_q, flags_q}, 12'h000);
        rst = 1'b0; cap_i = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(int'(VEC[i][33:31]), int'(VEC[i][30]), int'(VEC[i][29]),
                  int'(VEC[i][28]), int'(VEC[i][27:20]), int'(VEC[i][19:12]));
            #1;
            chk(tag(int'(VEC[i][33:31]), int'(VEC[i][30])),
                {res_o, n_o, v_o, z_o, c_o}, VEC[i][11:0]);
        end

        // R1 R2 R3 R4 R5: full sweep of add/subtract in both modes
        for (int op = 0; op < 2; op++)
            for (int dm = 0; dm < 2; dm++)
                for (int ci = 0; ci < 2; ci++)
                    for (int a = 0; a < 256; a++)
                        for (int b = 0; b < 256; b++)
                            run_one(op, dm, ci, (a ^ b) & 1, a, b);

        // R6 R7 R8: all byte pairs, flag and mode inputs varied
        for (int op = 2; op < 8; op++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++)
                    run_one(op, (a >> 1) & 1, a & 1, b & 1, a, b);

        // R9: capture on strobe
        @(negedge clk);
        drive(0, 0, 0, 0, 8'h50, 8'h50);
        cap_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R9", {res_q, flags_q}, {8'hA0, 4'b1100});
        // R9: hold while strobe low, even as inputs change
        cap_i = 1'b0;
        drive(0, 0, 1, 0, 8'hFF, 8'h00);
        @(posedge clk);
        @(negedge clk);
        chk("R9", {res_q, flags_q}, {8'hA0, 4'b1100});
        chk("R1", {res_o, n_o, v_o, z_o, c_o}, {8'h00, 4'b0011});
        // R9: second capture of a decimal result
        drive(1, 1, 1, 1, 8'h12, 8'h21);
        cap_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R9", {res_q, flags_q}, {8'h91, 4'b0000});
        // R10: reset clears captured state
        drive(0, 0, 1, 0, 8'h7F, 8'h7F);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R10", {res_q, flags_q}, 12'h000);
        rst = 1'b0; cap_i = 1'b0;
        @(posedge clk);
        @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule